// File: doc/BRIEF.md
# Second-Stage Address Translation Walker

This block converts an intermediate physical address into an output physical address. It walks a multi-level table of 64-bit descriptors held in memory. A requester presents an address and a read/write permission over a valid/ready handshake. The block then issues one descriptor read at a time over a simple memory port. It finishes with a one-cycle result pulse that carries either a translation or a typed fault. The configuration is static during a walk and consists of:

- the granule size;
- the T0SZ input-size field;
- the starting-level field;
- the table base;
- the access-flag fault disable;
- the effective output size;
- the input address size.

Before the walk begins, two size checks run in a fixed order:

1. The input address is checked against the input address size. A failure here is reported as a stage-1 fault.
2. The address is checked against the region that T0SZ configures.

The starting level follows from the granule and the starting-level field. When the first level spans more address bits than one table resolves, several tables sit back to back. In that case the upper address bits choose among them. Once a walk reaches a terminal descriptor, three checks run in priority order: access flag, then permission, then output size.

Top module: `s2w_walker`

## Requirements
- R1: `req_ready` is high only while the block is idle. Each accepted request produces exactly one `res_valid` pulse. `mem_req_valid` is a single-cycle pulse, and the next read is not issued before the previous response returns.
- R2: If the input address is at or above 2^`cfg_ias`, the block reports fault code 4 (address size) with stage 1. No descriptor read is made, and this check wins over every other check.
- R3: The input region size is 64 − `cfg_t0sz`. An address at or above 2^(64 − `cfg_t0sz`) that passes R2 gives fault code 1 (translation) with stage 2 and no read.
- R4: Granule selector 0 means 4 KB (log2 12), 1 means 16 KB (log2 14), and 2 or 3 mean 64 KB (log2 16). The start level is 2 − `cfg_sl0` for 4 KB and 3 − `cfg_sl0` otherwise. A negative start level gives a stage-2 translation fault.
- R5: The level shift is (g − 3)·(4 − level) + 3, where g is the granule log2. The first table address has two parts:
  - the base, cleared below bit (inputsize − (g − 3)·(4 − start)), plus (IA >> shift(start − 1)) · 2^g;
  - within each table, entry ((IA >> shift(level)) mod 2^(g − 3)) is read at byte offset entry·8.
- R6: Descriptor bits [1:0] are decoded as follows:
  - 2'b11 below level 3 is a table whose next base is bits [47:g];
  - 2'b11 at level 3 is a page;
  - 2'b01 below level 3 is a block;
  - anything else is invalid or reserved and gives a stage-2 translation fault (code 1).
- R7: Descriptor bit 10 is the access flag. When it is 0 and `cfg_affd` is 0, the result is fault code 2 (access). This fault is raised even if the permission check would also fail. When `cfg_affd` is 1, the flag is ignored.
- R8: Descriptor bits [7:6] hold the granted rights, with bit 6 for read and bit 7 for write. `req_perm` uses bit 0 for read and bit 1 for write. Unless every requested bit is granted, the result is fault code 3 (permission).
- R9: If the terminal output base is at or above 2^`cfg_ps`, the result is fault code 4 with stage 2.
- R10: On success the fault code is 0 and `res_stage` is 2. The result fields are:
  - `res_mask` is 2^shift(level) − 1;
  - `res_oa` is the descriptor address with the mask bits cleared;
  - `res_ia_base` is the input address with the mask bits cleared;
  - `res_perm` is descriptor bits [7:6];
  - `res_level` is the terminal level;
  - `res_gran` is the selector.
- R11: A memory response flagged with `mem_rsp_err` ends the walk with fault code 5 and stage 2. Every fault returns `res_perm` = 0.
- R12: While and after reset, the block is idle: `req_ready` = 1, `res_valid` = 0, `mem_req_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_ia | input | 48 | Intermediate physical address |
| req_perm | input | 2 | Requested rights, bit0 read, bit1 write |
| cfg_gran | input | 2 | Granule selector |
| cfg_t0sz | input | 6 | Input region size field |
| cfg_sl0 | input | 2 | Starting-level field |
| cfg_base | input | 48 | Table base address |
| cfg_affd | input | 1 | Disable access-flag faults |
| cfg_ps | input | 6 | Effective output address size |
| cfg_ias | input | 6 | Input address size |
| mem_req_valid | output | 1 | Descriptor read strobe |
| mem_req_addr | output | 48 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Descriptor |
| mem_rsp_err | input | 1 | Read failed |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 3 | Fault code, 0 for success |
| res_stage | output | 2 | Stage that faulted (1 or 2) |
| res_oa | output | 48 | Output base address |
| res_ia_base | output | 48 | Input address aligned to the mapping |
| res_mask | output | 48 | Mapping size minus one |
| res_perm | output | 2 | Granted rights |
| res_level | output | 2 | Terminal level |
| res_gran | output | 2 | Granule selector echoed |

## Verification
Two kinds of overlap matter, and each is provoked with one descriptor or one address that fails on two counts at once.

The terminal checks can fire in the same cycle. One case is a block whose access flag is clear and which is read-only, requested for writing. It must report an access fault, not a permission fault. A second case is a page whose rights lack the requested one. A third is a block that maps above the output size.

The two pre-walk size checks also overlap. An address above both the input address size and the T0SZ region must report the stage-1 address-size fault. The bench also confirms that no descriptor read was issued for that request.

// File: rtl/s2w_pkg.sv
`timescale 1ns/1ps
package s2w_pkg;
    localparam int AW   = 48;   // address width
    localparam int DW   = 64;   // descriptor width
    localparam int LVLS = 4;    // levels 0..3

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_TRANSL = 3'd1,
        FLT_ACCESS = 3'd2,
        FLT_PERM   = 3'd3,
        FLT_ADDRSZ = 3'd4,
        FLT_EXTABT = 3'd5
    } fault_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_FETCH, S_WAIT, S_DONE
    } wstate_e;

    function automatic int gran_log2(input logic [1:0] sel);
        case (sel)
            2'd0:    return 12;
            2'd1:    return 14;
            default: return 16;
        endcase
    endfunction

    function automatic int lvl_shift(input int g, input int lvl);
        return (g - 3) * (LVLS - lvl) + 3;
    endfunction

    function automatic int first_level(input int g, input logic [1:0] sl0);
        return ((g == 12) ? 2 : 3) - int'(sl0);
    endfunction

    function automatic logic [AW-1:0] low_mask(input int n);
        if (n <= 0)  return '0;
        if (n >= AW) return {AW{1'b1}};
        return {AW{1'b1}} >> (AW - n);
    endfunction

    function automatic logic at_or_above(input logic [AW-1:0] a, input int n);
        if (n >= AW) return 1'b0;
        return (a & ~low_mask(n)) != '0;
    endfunction
endpackage

// File: rtl/s2w_start.sv
`timescale 1ns/1ps
module s2w_start
    import s2w_pkg::*;
(
    input  logic [AW-1:0] ia,
    input  logic [1:0]    gran,
    input  logic [5:0]    t0sz,
    input  logic [1:0]    sl0,
    input  logic [AW-1:0] base,
    input  logic [5:0]    ias,
    output logic [1:0]    lvl,
    output logic [AW-1:0] tbl,
    output fault_e        flt,
    output logic [1:0]    stg
);
    int g, isz, sl, al, shp;
    logic [AW-1:0] cidx;

    always_comb begin
        g   = gran_log2(gran);
        isz = 64 - int'(t0sz);
        sl  = first_level(g, sl0);
        al  = isz - (g - 3) * (LVLS - sl);
        shp = lvl_shift(g, sl - 1);
        // which of the back-to-back first-level tables to use
        cidx = (shp >= AW) ? {AW{1'b0}} : (ia >> shp);
        tbl  = (base & ~low_mask(al)) + (cidx << g);
        lvl  = (sl < 0) ? 2'd0 : 2'(sl);
        flt  = FLT_NONE;
        stg  = 2'd2;
        if (at_or_above(ia, int'(ias))) begin
            flt = FLT_ADDRSZ;
            stg = 2'd1;
        end else if (at_or_above(ia, isz) || (sl < 0)) begin
            flt = FLT_TRANSL;
        end
    end
endmodule

// File: rtl/s2w_desc.sv
`timescale 1ns/1ps
module s2w_desc
    import s2w_pkg::*;
(
    input  logic [DW-1:0] desc,
    input  logic [1:0]    lvl,
    input  logic [1:0]    gran,
    input  logic [1:0]    perm,
    input  logic          affd,
    input  logic [5:0]    ps,
    output logic          is_table,
    output logic [AW-1:0] next_base,
    output fault_e        flt,
    output logic [AW-1:0] oa,
    output logic [AW-1:0] mask,
    output logic [1:0]    dperm
);
    int g, sh;
    logic terminal;
    logic unused_bits;

    assign unused_bits = ^{desc[DW-1:AW], desc[9:8], desc[5:2]};

    always_comb begin
        g         = gran_log2(gran);
        sh        = lvl_shift(g, int'(lvl));
        is_table  = (desc[1:0] == 2'b11) && (lvl != 2'd3);
        terminal  = ((desc[1:0] == 2'b11) && (lvl == 2'd3)) ||
                    ((desc[1:0] == 2'b01) && (lvl != 2'd3));
        next_base = desc[AW-1:0] & ~low_mask(g);
        mask      = low_mask(sh);
        oa        = desc[AW-1:0] & ~mask;
        dperm     = desc[7:6];
        if (!terminal && !is_table)
            flt = FLT_TRANSL;
        else if (!desc[10] && !affd)
            flt = FLT_ACCESS;
        else if ((dperm & perm) != perm)
            flt = FLT_PERM;
        else if (at_or_above(oa, int'(ps)))
            flt = FLT_ADDRSZ;
        else
            flt = FLT_NONE;
    end
endmodule

// File: rtl/s2w_walker.sv
`timescale 1ns/1ps
module s2w_walker
    import s2w_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [47:0]     req_ia,
    input  logic [1:0]      req_perm,
    input  logic [1:0]      cfg_gran,
    input  logic [5:0]      cfg_t0sz,
    input  logic [1:0]      cfg_sl0,
    input  logic [47:0]     cfg_base,
    input  logic            cfg_affd,
    input  logic [5:0]      cfg_ps,
    input  logic [5:0]      cfg_ias,
    output logic            mem_req_valid,
    output logic [47:0]     mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [63:0]     mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            res_valid,
    output logic [2:0]      res_fault,
    output logic [1:0]      res_stage,
    output logic [47:0]     res_oa,
    output logic [47:0]     res_ia_base,
    output logic [47:0]     res_mask,
    output logic [1:0]      res_perm,
    output logic [1:0]      res_level,
    output logic [1:0]      res_gran
);
    wstate_e       state;
    logic [AW-1:0] ia_q, base_q;
    logic [1:0]    perm_q, lvl_q;
    fault_e        flt_q;

    logic [1:0]    st_lvl, st_stg;
    logic [AW-1:0] st_tbl;
    fault_e        st_flt;

    logic          d_table;
    logic [AW-1:0] d_next, d_oa, d_mask;
    fault_e        d_flt;
    logic [1:0]    d_perm;

    int g, sh;

    s2w_start u_start (
        .ia(ia_q), .gran(cfg_gran), .t0sz(cfg_t0sz), .sl0(cfg_sl0),
        .base(cfg_base), .ias(cfg_ias),
        .lvl(st_lvl), .tbl(st_tbl), .flt(st_flt), .stg(st_stg)
    );

    s2w_desc u_desc (
        .desc(mem_rsp_data), .lvl(lvl_q), .gran(cfg_gran), .perm(perm_q),
        .affd(cfg_affd), .ps(cfg_ps),
        .is_table(d_table), .next_base(d_next), .flt(d_flt),
        .oa(d_oa), .mask(d_mask), .dperm(d_perm)
    );

    always_comb begin
        g            = gran_log2(cfg_gran);
        sh           = lvl_shift(g, int'(lvl_q));
        mem_req_addr = base_q + (((ia_q >> sh) & low_mask(g - 3)) << 3);
    end

    assign req_ready     = (state == S_IDLE);
    assign mem_req_valid = (state == S_FETCH);
    assign res_valid     = (state == S_DONE);
    assign res_fault     = flt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            ia_q        <= '0;
            perm_q      <= '0;
            base_q      <= '0;
            lvl_q       <= '0;
            flt_q       <= FLT_NONE;
            res_stage   <= '0;
            res_oa      <= '0;
            res_ia_base <= '0;
            res_mask    <= '0;
            res_perm    <= '0;
            res_level   <= '0;
            res_gran    <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    ia_q   <= req_ia;
                    perm_q <= req_perm;
                    state  <= S_CHECK;
                end
                S_CHECK: begin
                    res_gran <= cfg_gran;
                    if (st_flt != FLT_NONE) begin
                        flt_q       <= st_flt;
                        res_stage   <= st_stg;
                        res_perm    <= '0;
                        res_oa      <= '0;
                        res_ia_base <= '0;
                        res_mask    <= '0;
                        res_level   <= '0;
                        state       <= S_DONE;
                    end else begin
                        lvl_q  <= st_lvl;
                        base_q <= st_tbl;
                        state  <= S_FETCH;
                    end
                end
                S_FETCH: state <= S_WAIT;
                S_WAIT: if (mem_rsp_valid) begin
                    if (!mem_rsp_err && d_table) begin
                        base_q <= d_next;
                        lvl_q  <= lvl_q + 2'd1;
                        state  <= S_FETCH;
                    end else begin
                        res_stage <= 2'd2;
                        res_level <= lvl_q;
                        state     <= S_DONE;
                        if (mem_rsp_err || d_flt != FLT_NONE) begin
                            flt_q       <= mem_rsp_err ? FLT_EXTABT : d_flt;
                            res_perm    <= '0;
                            res_oa      <= '0;
                            res_ia_base <= '0;
                            res_mask    <= '0;
                        end else begin
                            flt_q       <= FLT_NONE;
                            res_perm    <= d_perm;
                            res_oa      <= d_oa;
                            res_ia_base <= ia_q & ~d_mask;
                            res_mask    <= d_mask;
                        end
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R1
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !req_ready);
    // R1
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);
    // R11
    flt_noperm_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault != FLT_NONE) |-> (res_perm == 2'd0));
    // R2
    s1_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_stage == 2'd1) |-> (res_fault == FLT_ADDRSZ));
    // R10
    align_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault == FLT_NONE) |->
            (((res_ia_base & res_mask) == '0) && ((res_oa & res_mask) == '0)));
    // R1
    one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
endmodule

// File: tb/s2w_walker_test.sv
`timescale 1ns/1ps
module s2w_walker_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        req_valid = 0, req_ready;
    logic [47:0] req_ia = 0;
    logic [1:0]  req_perm = 0;
    logic [1:0]  cfg_gran = 0, cfg_sl0 = 1;
    logic [5:0]  cfg_t0sz = 25, cfg_ps = 40, cfg_ias = 48;
    logic [47:0] cfg_base = 48'h10000;
    logic        cfg_affd = 0;
    logic        mem_req_valid;
    logic [47:0] mem_req_addr;
    logic        mem_rsp_valid = 0, mem_rsp_err = 0;
    logic [63:0] mem_rsp_data = 0;
    logic        res_valid;
    logic [2:0]  res_fault;
    logic [1:0]  res_stage, res_perm, res_level, res_gran;
    logic [47:0] res_oa, res_ia_base, res_mask;

    s2w_walker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_ia(req_ia), .req_perm(req_perm), .cfg_gran(cfg_gran),
        .cfg_t0sz(cfg_t0sz), .cfg_sl0(cfg_sl0), .cfg_base(cfg_base),
        .cfg_affd(cfg_affd), .cfg_ps(cfg_ps), .cfg_ias(cfg_ias),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err), .res_valid(res_valid), .res_fault(res_fault),
        .res_stage(res_stage), .res_oa(res_oa), .res_ia_base(res_ia_base),
        .res_mask(res_mask), .res_perm(res_perm), .res_level(res_level),
        .res_gran(res_gran)
    );

    int checks = 0, errors = 0, reads = 0;
    logic [63:0] mem [logic [47:0]];
    logic [47:0] err_addr = 48'h20018;
    logic [47:0] pend_addr = 0;
    int          lat = 0;

    // memory model: response two negedges after a read strobe
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        if (lat > 0) begin
            lat = lat - 1;
            if (lat == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_err   = (pend_addr == err_addr);
                mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
            end
        end
        if (mem_req_valid) begin
            if (lat != 0) begin
                errors++;
                $display("FAIL R1 overlapping read actual=%0d expected=0", lat);
            end
            lat = 2;
            pend_addr = mem_req_addr;
            reads++;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic        got;
    logic [2:0]  g_flt;
    logic [1:0]  g_stg, g_perm, g_lvl;
    logic [47:0] g_oa, g_iab, g_mask;

    task automatic walk(input logic [47:0] ia, input logic [1:0] perm);
        int n;
        @(negedge clk);
        req_valid = 1; req_ia = ia; req_perm = perm;
        @(negedge clk);
        req_valid = 0;
        n = 0;
        while (!res_valid && n < 500) begin
            @(negedge clk);
            n++;
        end
        got = res_valid;
        g_flt = res_fault; g_stg = res_stage; g_perm = res_perm; g_lvl = res_level;
        g_oa = res_oa; g_iab = res_ia_base; g_mask = res_mask;
        check(got, "R1 result pulse", {63'd0, got}, 64'd1);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [47:0] ia;
        logic [1:0]  perm;
        logic [2:0]  flt;
        logic [1:0]  stg;
        logic [47:0] oa;
        logic [1:0]  lvl;
        logic [1:0]  gp;
    } vec_t;

    localparam int NV = 12;
    // 4 KB granule, start level 1, input size 39, output size 40
    localparam vec_t VECS [NV] = '{
        '{48'h0000_4000_0123, 2'd3, 3'd0, 2'd2, 48'h0000_8000_0000, 2'd1, 2'd3}, // R10 block
        '{48'h0000_0000_0ABC, 2'd1, 3'd0, 2'd2, 48'h0000_5555_5000, 2'd3, 2'd3}, // R6 page
        '{48'h0000_0020_5000, 2'd1, 3'd0, 2'd2, 48'h0000_1240_0000, 2'd2, 2'd1}, // R6 block L2
        '{48'h0000_0020_0000, 2'd2, 3'd3, 2'd2, 48'h0,              2'd0, 2'd0}, // R8 perm
        '{48'h0000_0040_0000, 2'd2, 3'd2, 2'd2, 48'h0,              2'd0, 2'd0}, // R7 priority
        '{48'h0000_8000_0000, 2'd1, 3'd1, 2'd2, 48'h0,              2'd0, 2'd0}, // R6 invalid
        '{48'h0000_C000_0000, 2'd1, 3'd2, 2'd2, 48'h0,              2'd0, 2'd0}, // R7 AF=0
        '{48'h0001_0000_0000, 2'd1, 3'd4, 2'd2, 48'h0,              2'd0, 2'd0}, // R9 OA size
        '{48'h0000_0000_1000, 2'd1, 3'd1, 2'd2, 48'h0,              2'd0, 2'd0}, // R6 reserved
        '{48'h0000_0000_2000, 2'd2, 3'd0, 2'd2, 48'h0000_7777_7000, 2'd3, 2'd2}, // R8 write-only
        '{48'h0000_0000_2000, 2'd1, 3'd3, 2'd2, 48'h0,              2'd0, 2'd0}, // R8 read denied
        '{48'h0080_0000_0000, 2'd1, 3'd1, 2'd2, 48'h0,              2'd0, 2'd0}  // R3 input size
    };

    function automatic logic [47:0] mask4k(input logic [1:0] l);
        return (48'h1 << (9 * (4 - int'(l)) + 3)) - 48'h1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r0;
        mem[48'h10000] = 64'h0000_0000_0002_0003;
        mem[48'h10008] = 64'h0000_0000_8000_04C1;
        mem[48'h10010] = 64'h0;
        mem[48'h10018] = 64'h0000_0000_C000_00C1;
        mem[48'h10020] = 64'h0000_4000_0000_04C1;
        mem[48'h20000] = 64'h0000_0000_0003_0003;
        mem[48'h20008] = 64'h0000_0000_1240_0441;
        mem[48'h20010] = 64'h0000_0000_1260_0041;
        mem[48'h30000] = 64'h0000_0000_5555_54C3;
        mem[48'h30008] = 64'h0000_0000_0000_0001;
        mem[48'h30010] = 64'h0000_0000_7777_7483;
        mem[48'h11008] = 64'h0000_0009_C000_04C1;
        mem[48'h40008] = 64'h0000_0002_4000_04C1;

        // R12 reset state
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R12 ready in reset", {63'd0, req_ready}, 64'd1);
        check(res_valid == 1'b0, "R12 no result in reset", {63'd0, res_valid}, 64'd0);
        check(mem_req_valid == 1'b0, "R12 no read in reset", {63'd0, mem_req_valid}, 64'd0);
        rst = 0;
        @(negedge clk);
        check(req_ready == 1'b1, "R12 idle after reset", {63'd0, req_ready}, 64'd1);

        for (int i = 0; i < NV; i++) begin
            walk(VECS[i].ia, VECS[i].perm);
            check(g_flt == VECS[i].flt, $sformatf("R6/R7/R8/R9 vec%0d fault", i),
                  {61'd0, g_flt}, {61'd0, VECS[i].flt});
            check(g_stg == VECS[i].stg, $sformatf("R11 vec%0d stage", i),
                  {62'd0, g_stg}, {62'd0, VECS[i].stg});
            check(g_perm == VECS[i].gp, $sformatf("R10/R11 vec%0d perm", i),
                  {62'd0, g_perm}, {62'd0, VECS[i].gp});
            if (VECS[i].flt == 3'd0) begin
                check(g_oa == VECS[i].oa, $sformatf("R10 vec%0d oa", i),
                      {16'd0, g_oa}, {16'd0, VECS[i].oa});
                check(g_lvl == VECS[i].lvl, $sformatf("R10 vec%0d level", i),
                      {62'd0, g_lvl}, {62'd0, VECS[i].lvl});
                check(g_mask == mask4k(VECS[i].lvl), $sformatf("R10 vec%0d mask", i),
                      {16'd0, g_mask}, {16'd0, mask4k(VECS[i].lvl)});
                check(g_iab == (VECS[i].ia & ~mask4k(VECS[i].lvl)),
                      $sformatf("R10 vec%0d ia base", i), {16'd0, g_iab},
                      {16'd0, VECS[i].ia & ~mask4k(VECS[i].lvl)});
            end
        end

        // R7 disable bit: AF=0 block now succeeds
        cfg_affd = 1;
        walk(48'h0000_C000_0000, 2'd1);
        check(g_flt == 3'd0, "R7 affd ignores flag", {61'd0, g_flt}, 64'd0);
        check(g_oa == 48'hC000_0000, "R7 affd oa", {16'd0, g_oa}, 64'hC000_0000);
        cfg_affd = 0;

        // R2 stage-1 size fault beats R3, no reads
        cfg_ias = 40;
        r0 = reads;
        walk(48'h0100_0000_0000, 2'd1);
        check(g_flt == 3'd4 && g_stg == 2'd1, "R2 stage1 size fault",
              {59'd0, g_flt, g_stg}, {59'd0, 3'd4, 2'd1});
        check(reads == r0, "R2 no descriptor read", 64'(reads - r0), 64'd0);
        cfg_ias = 48;

        // R11 external abort at level 2
        walk(48'h0000_0060_0000, 2'd1);
        check(g_flt == 3'd5 && g_stg == 2'd2 && g_perm == 2'd0, "R11 external abort",
              {57'd0, g_flt, g_stg, g_perm}, {57'd0, 3'd5, 2'd2, 2'd0});

        // R4 negative start level
        cfg_sl0 = 3;
        r0 = reads;
        walk(48'h0000_0000_0ABC, 2'd1);
        check(g_flt == 3'd1 && reads == r0, "R4 bad start level",
              {61'd0, g_flt}, 64'd1);
        cfg_sl0 = 1;

        // R5 concatenated first level: 40-bit input, IA bit 39 picks table 1
        cfg_t0sz = 24;
        walk(48'h0080_4000_0000, 2'd3);
        check(g_flt == 3'd0 && g_oa == 48'h9_C000_0000, "R5 concatenated table",
              {16'd0, g_oa}, 64'h9_C000_0000);
        check(g_lvl == 2'd1, "R5 concat level", {62'd0, g_lvl}, 64'd1);

        // R4 64 KB granule, start level 2, 512 MB block
        cfg_gran = 2; cfg_t0sz = 22; cfg_base = 48'h40000; cfg_ps = 40;
        walk(48'h0000_2000_1234, 2'd1);
        check(g_flt == 3'd0 && g_lvl == 2'd2, "R4 64KB start level",
              {61'd0, g_flt}, 64'd0);
        check(g_oa == 48'h2_4000_0000, "R4 64KB oa", {16'd0, g_oa}, 64'h2_4000_0000);
        check(g_mask == 48'h1FFF_FFFF, "R10 64KB mask", {16'd0, g_mask}, 64'h1FFF_FFFF);
        check(g_iab == 48'h2000_0000, "R10 64KB ia base", {16'd0, g_iab}, 64'h2000_0000);
        check(res_gran == 2'd2, "R10 granule echo", {62'd0, res_gran}, 64'd2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule